// File: doc/BRIEF.md
# Skip-Symbol Clock Compensation FIFO

This block is a receive-side elastic buffer. It sits between a write side that runs from a recovered clock and a read side that runs from the local clock, and it absorbs the small frequency difference between the two. Each entry holds one decoded symbol and its control flag. The buffer changes its own contents to keep its occupancy near the middle. When the buffer is too full, it drops a skip symbol from a skip ordered set. When the buffer is too empty, it repeats a skip symbol. In both cases the data symbols pass through unchanged and in their original order.

Both sides share one clock in this model. The write-valid and read-enable strobes set the rate of each side, so a strobe pattern stands in for the frequency offset. Compensation is held off until the synchronization input goes high. While that input is low, the buffer stays empty.

Top module: `skp_elastic_fifo`

## Requirements
- R1: The buffer holds 20 entries. `full_o` is high while 20 entries are stored. A write that arrives while the buffer is full is discarded, and the stored entries and their order stay intact.
- R2: A read while the buffer is empty (`empty_o` high) delivers nothing. In the following cycle `rd_valid_o` is low and `rd_sym_o`/`rd_k_o` keep their previous values.
- R3: While `sync_i` is low, the buffer is held empty. Writes are ignored, and `ins_o` and `del_o` stay low. In the cycle after `sync_i` goes low, `empty_o` is high.
- R4: A skip written with occupancy above 13 is deleted, and `del_o` pulses one cycle later. This happens only when all of these hold: the skip is inside a set, the same set already holds at least one stored skip, and no skip has been deleted from that set yet.
- R5: A read of the last skip of a set, with occupancy below 7, delivers that skip twice, and `ins_o` pulses with the first of the two. This happens only when all of these hold: the next stored entry is present and is not a skip, the set has delivered at most three skips before this one, and no skip has been inserted into the set yet.
- R6: Symbol encoding: a comma is 0xBC with K=1, and a skip is 0x1C with K=1. A set begins with a comma and continues over the skips that follow it. A skip that is not in a set is never deleted or repeated. The value 0x1C with K=0 is ordinary data.
- R7: All symbols other than skips leave the buffer in exactly the order they were written, with none lost or added. This holds under any write/read strobe ratio within the compensation range.
- R8: Every skip ordered set at the output holds between one and five skips, given input sets of one to five skips.
- R9: Read data appears on `rd_sym_o`/`rd_k_o` with `rd_valid_o` high one cycle after the `rd_en_i` cycle that reads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Synchronization acquired; low holds the buffer empty |
| wr_valid_i | input | 1 | Write strobe |
| wr_sym_i | input | 8 | Written symbol value |
| wr_k_i | input | 1 | Written symbol control flag |
| rd_en_i | input | 1 | Read strobe |
| rd_sym_o | output | 8 | Read symbol value |
| rd_k_o | output | 1 | Read symbol control flag |
| rd_valid_o | output | 1 | Read symbol delivered this cycle |
| ins_o | output | 1 | Pulse: a skip was repeated |
| del_o | output | 1 | Pulse: a skip was dropped |
| full_o | output | 1 | Buffer holds 20 entries |
| empty_o | output | 1 | Buffer holds no entries |

## Verification
The bench builds the block with its default depth of 20 and marks of 13 and 7. At this size, a single burst of 22 writes covers the full boundary, and a directed fill of 14 entries puts a set straight into the deletion zone. The bench then sweeps seven write/read strobe ratios, from equal rates to offsets of one part in 40 in either direction, each over 100 sets. This brings both the insertion and the deletion paths into steady operation. The output stream of every run is compared against the data order and the set-size limits, which the bench computes itself.

// File: rtl/skp_elastic_fifo.sv
module skp_elastic_fifo #(
  parameter int          SYM_W   = 8,
  parameter int          DEPTH   = 20,
  parameter int          HI_MARK = 13,
  parameter int          LO_MARK = 7,
  parameter int          MAX_SKP = 5,
  parameter logic [SYM_W-1:0] COMMA = 8'hBC,
  parameter logic [SYM_W-1:0] SKIP  = 8'h1C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic             wr_valid_i,
  input  logic [SYM_W-1:0] wr_sym_i,
  input  logic             wr_k_i,
  input  logic             rd_en_i,
  output logic [SYM_W-1:0] rd_sym_o,
  output logic             rd_k_o,
  output logic             rd_valid_o,
  output logic             ins_o,
  output logic             del_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int RW = $clog2(MAX_SKP + 1);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] HI_C   = CW'(HI_MARK);
  localparam logic [CW-1:0] LO_C   = CW'(LO_MARK);
  localparam logic [CW-1:0] TWO_C  = CW'(2);
  localparam logic [RW-1:0] RUN_LIM = RW'(MAX_SKP - 2);
  localparam logic [RW-1:0] RUN_MAX = RW'(MAX_SKP);
  localparam logic [PW-1:0] LAST_P  = PW'(DEPTH - 1);

  logic [SYM_W:0]  mem [DEPTH];
  logic [PW-1:0]   wp, rp, rp_nx;
  logic [CW-1:0]   cnt;
  logic            w_set, w_del_done, r_set, r_ins_done;
  logic [RW-1:0]   w_run, r_run;

  assign full_o  = (cnt == FULL_C);
  assign empty_o = (cnt == '0);

  wire w_comma = wr_k_i && (wr_sym_i == COMMA);
  wire w_skip  = wr_k_i && (wr_sym_i == SKIP);

  wire del_now = sync_i && wr_valid_i && w_skip && w_set && (w_run != '0)
                 && !w_del_done && (cnt > HI_C);
  wire wr_go   = sync_i && wr_valid_i && !del_now && !full_o;

  assign rp_nx = (rp == LAST_P) ? '0 : rp + 1'b1;
  wire [SYM_W:0] head = mem[rp];
  wire [SYM_W:0] peek = mem[rp_nx];
  wire h_comma = head[SYM_W] && (head[SYM_W-1:0] == COMMA);
  wire h_skip  = head[SYM_W] && (head[SYM_W-1:0] == SKIP);
  wire p_skip  = peek[SYM_W] && (peek[SYM_W-1:0] == SKIP);

  wire rd_go   = sync_i && rd_en_i && !empty_o;
  wire ins_now = rd_go && h_skip && r_set && !r_ins_done && (cnt >= TWO_C)
                 && !p_skip && (r_run <= RUN_LIM) && (cnt < LO_C);
  wire rd_adv  = rd_go && !ins_now;

  always_ff @(posedge clk) begin
    if (wr_go) mem[wp] <= {wr_k_i, wr_sym_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
      w_set <= 1'b0; w_run <= '0; w_del_done <= 1'b0;
      r_set <= 1'b0; r_run <= '0; r_ins_done <= 1'b0;
    end else if (!sync_i) begin
      wp <= '0; rp <= '0; cnt <= '0;
      w_set <= 1'b0; w_run <= '0; w_del_done <= 1'b0;
      r_set <= 1'b0; r_run <= '0; r_ins_done <= 1'b0;
    end else begin
      if (wr_go) wp <= (wp == LAST_P) ? '0 : wp + 1'b1;
      if (rd_adv) rp <= rp_nx;
      cnt <= cnt + CW'(wr_go) - CW'(rd_adv);
      if (wr_valid_i) begin
        if (w_comma) begin
          w_set <= 1'b1; w_run <= '0; w_del_done <= 1'b0;
        end else if (w_skip) begin
          if (wr_go && w_set && w_run != RUN_MAX) w_run <= w_run + 1'b1;
          if (del_now) w_del_done <= 1'b1;
        end else begin
          w_set <= 1'b0; w_run <= '0;
        end
      end
      if (rd_go) begin
        if (h_comma) begin
          r_set <= 1'b1; r_run <= '0; r_ins_done <= 1'b0;
        end else if (h_skip) begin
          if (r_set) r_run <= r_run + 1'b1;
          if (ins_now) r_ins_done <= 1'b1;
        end else begin
          r_set <= 1'b0; r_run <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sym_o <= '0; rd_k_o <= 1'b0; rd_valid_o <= 1'b0;
      ins_o <= 1'b0; del_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_go;
      ins_o      <= ins_now;
      del_o      <= del_now;
      if (rd_go) begin
        rd_sym_o <= head[SYM_W-1:0];
        rd_k_o   <= head[SYM_W];
      end
    end
  end

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_C);
  p_empty_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && empty_o) |=> (!rd_valid_o && $stable(rd_sym_o) && $stable(rd_k_o)));
  p_unsync_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_i |=> (empty_o && !ins_o && !del_o));
  p_del_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    del_o |-> $past(cnt) > HI_C);
  p_ins_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ins_o |-> ($past(cnt) < LO_C && rd_valid_o));
  p_ins_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ins_o |=> !ins_o);
  p_set_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    r_run <= RUN_MAX);
endmodule

// File: tb/skp_elastic_fifo_tb_top.sv
`timescale 1ns/1ps
module skp_elastic_fifo_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, sync = 1'b0;
  logic wv = 1'b0, wk = 1'b0, re = 1'b0;
  logic [7:0] ws = '0;
  logic [7:0] rs; logic rk, rv, ins, del, full, empty;
  int errors = 0, checks = 0;
  logic [8:0] cap [8192];
  logic [8:0] expq [8192];
  int ncap = 0, nexp = 0, nins = 0, ndel = 0;

  always #2 clk = ~clk;

  skp_elastic_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .sync_i(sync), .wr_valid_i(wv), .wr_sym_i(ws),
    .wr_k_i(wk), .rd_en_i(re), .rd_sym_o(rs), .rd_k_o(rk), .rd_valid_o(rv),
    .ins_o(ins), .del_o(del), .full_o(full), .empty_o(empty));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit w, input logic [7:0] s, input bit k, input bit r);
    @(negedge clk);
    wv = w; ws = s; wk = k; re = r;
    @(posedge clk); #1;
    if (rv && ncap < 8192) begin cap[ncap] = {rk, rs}; ncap++; end
    if (ins) nins++;
    if (del) ndel++;
  endtask

  task automatic clear_log();
    ncap = 0; nexp = 0; nins = 0; ndel = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sync = 1'b0; wv = 0; re = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; sync = 1'b1;
    clear_log();
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && !empty; i++) step(0, 8'h00, 0, 1);
    step(0, 8'h00, 0, 0);
  endtask

  function automatic logic [8:0] gen(input int n);
    int p = n % 12;
    if (p < 8) return {1'b0, 8'((n * 7 + 3) & 255)};
    if (p == 8) return 9'h1BC;
    return 9'h11C;
  endfunction

  task automatic analyse(input string tag);
    int ei = 0, mism = 0, bad = 0, sc = 0;
    bit inset = 0;
    for (int i = 0; i < ncap; i++) begin
      if (cap[i] == 9'h11C) begin
        if (inset) sc++; else bad++;
      end else begin
        if (inset && (sc < 1 || sc > 5)) bad++;
        inset = (cap[i] == 9'h1BC); sc = 0;
        if (ei >= nexp || cap[i] != expq[ei]) mism++;
        ei++;
      end
    end
    if (inset && (sc < 1 || sc > 5)) bad++;
    chk(mism == 0, {"R7 order ", tag}, mism, 0);
    chk(ei == nexp, {"R7 count ", tag}, ei, nexp);
    chk(bad == 0, {"R8 set size ", tag}, bad, 0);
  endtask

  task automatic run_ratio(input int wper, input int rper);
    int n = 0;
    string tag = $sformatf("w%0d r%0d", wper, rper);
    do_reset();
    for (int cyc = 0; n < 1200; cyc++) begin
      bit w = (wper == 0) || (cyc % wper != wper - 1);
      bit r = (cyc >= 10) && ((rper == 0) || (cyc % rper != rper - 1));
      logic [8:0] g = gen(n);
      if (w) begin
        if (g != 9'h11C) begin expq[nexp] = g; nexp++; end
        n++;
      end
      step(w, g[7:0], g[8], r);
    end
    drain();
    analyse(tag);
    if (wper == rper) chk(nins == 0 && ndel == 0, {"R4 R5 balanced ", tag}, nins + ndel, 0);
    else if (wper == 0 || (rper != 0 && wper > rper))
      chk(ndel > 0, {"R4 fast writer deletes ", tag}, ndel, 1);
    else chk(nins > 0, {"R5 slow writer inserts ", tag}, nins, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] last;
    do_reset();
    chk(empty === 1'b1 && full === 1'b0 && rv === 1'b0, "reset state R2", empty, 1);

    // R3: unsynchronised writes ignored
    sync = 1'b0;
    for (int i = 0; i < 5; i++) step(1, 8'(i + 40), 0, 0);
    chk(empty == 1'b1 && nins == 0 && ndel == 0, "R3 writes ignored", empty, 1);
    sync = 1'b1;
    step(0, 0, 0, 1); step(0, 0, 0, 0);
    chk(ncap == 0, "R3 nothing readable", ncap, 0);
    for (int i = 0; i < 5; i++) step(1, 8'(i), 0, 0);
    chk(empty == 1'b0, "R3 fills when synced", empty, 0);
    @(negedge clk); sync = 1'b0; step(0, 0, 0, 0);
    chk(empty == 1'b1, "R3 drop of sync empties", empty, 1);
    sync = 1'b1;

    // R1 / R9 / R2: full boundary and empty read
    do_reset();
    for (int i = 0; i < 22; i++) begin
      step(1, 8'(i + 100), 0, 0);
      if (i == 18) chk(full == 1'b0, "R1 not full at 19", full, 0);
      if (i == 19) chk(full == 1'b1, "R1 full at 20", full, 1);
    end
    step(0, 0, 0, 1);
    chk(rv == 1'b1 && rs == 8'd100, "R9 first read latency", rs, 100);
    drain();
    chk(ncap == 20, "R1 count after overfill", ncap, 20);
    begin
      int bad = 0;
      for (int i = 0; i < ncap; i++) if (cap[i] != {1'b0, 8'(i + 100)}) bad++;
      chk(bad == 0, "R1 stored order intact", bad, 0);
    end
    last = rs;
    step(0, 0, 0, 1);
    chk(rv == 1'b0 && rs == last && empty == 1'b1, "R2 empty read holds", rs, last);

    // R4: deletion inside a set above the high mark
    do_reset();
    for (int i = 0; i < 14; i++) step(1, 8'(i), 0, 0);
    step(1, 8'hBC, 1, 0); step(1, 8'h1C, 1, 0);
    step(1, 8'h1C, 1, 0); step(1, 8'h1C, 1, 0);
    step(0, 0, 0, 0);
    chk(ndel == 1, "R4 one deletion per set", ndel, 1);
    drain();
    chk(ncap == 17, "R4 stored after delete", ncap, 17);
    chk(cap[14] == 9'h1BC && cap[15] == 9'h11C && cap[16] == 9'h11C, "R4 two skips kept", ncap, 17);

    // R6: skips outside a set and K=0 lookalikes never deleted
    do_reset();
    for (int i = 0; i < 14; i++) step(1, 8'(i), 0, 0);
    step(1, 8'h1C, 1, 0); step(1, 8'h1C, 1, 0); step(1, 8'h1C, 0, 0);
    step(0, 0, 0, 0);
    chk(ndel == 0, "R6 lone skips kept", ndel, 0);
    drain();
    chk(ncap == 17, "R6 all stored", ncap, 17);

    // R5: insertion below the low mark
    do_reset();
    step(1, 8'hBC, 1, 0); step(1, 8'h1C, 1, 0); step(1, 8'h1C, 1, 0); step(1, 8'h55, 0, 0);
    drain();
    chk(nins == 1, "R5 one insertion", nins, 1);
    chk(ncap == 5 && cap[3] == 9'h11C && cap[4] == 9'h055, "R5 skip repeated", ncap, 5);

    // R5 / R8: four-skip set grows to five, five-skip set unchanged
    do_reset();
    step(1, 8'hBC, 1, 0);
    for (int i = 0; i < 4; i++) step(1, 8'h1C, 1, 0);
    step(1, 8'h66, 0, 0);
    drain();
    chk(nins == 1 && ncap == 7, "R8 four becomes five", ncap, 7);
    do_reset();
    step(1, 8'hBC, 1, 0);
    for (int i = 0; i < 5; i++) step(1, 8'h1C, 1, 0);
    step(1, 8'h77, 0, 0);
    drain();
    chk(nins == 0 && ncap == 7, "R8 five stays five", ncap, 7);

    // R7 / R8: strobe ratio sweep
    run_ratio(0, 0);
    run_ratio(0, 100);
    run_ratio(100, 0);
    run_ratio(0, 40);
    run_ratio(40, 0);
    run_ratio(50, 40);
    run_ratio(40, 50);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule